// File: doc/BRIEF.md
# Power-Good Indicator Controller

This block decides when a regulator's open-drain power-good pin is pulled low and when it is left floating. It watches five digital status lines (supply above lockout, enable, thermal trip, output inside its target window, and a voltage-change-in-progress flag). It drives a pull-down enable: 1 pulls the pin low and 0 releases it to high impedance.

Qualification is asymmetric. Any bad condition pulls the pin low as soon as the synchronised input shows it. A good condition must hold without a break for a programmable number of clock cycles before the pin is released. After the supply rises above lockout, the pin stays released until the device is enabled for the first time. A registered status bit reports the released state, for readback through a register interface.

Top module: `pg_indicator`

## Requirements
- R1: Each status input passes through two flip-flops before use. A change on any input that is applied between clock edges reaches `pg_pulldown_o` after exactly the second following rising edge, and not after the first.
- R2: While the supply is above lockout and the device has not been enabled since the supply last rose, `pg_pulldown_o` is 0 (pin released), whatever the window, thermal and transition inputs show.
- R3: Once the device has been enabled, a low `enable_i` holds `pg_pulldown_o` at 1 for as long as it stays low.
- R4: Once the device has been enabled, a high `thermal_trip_i` forces `pg_pulldown_o` to 1, whatever the window and transition inputs show.
- R5: Once the device has been enabled, a low `in_window_i` (output below target) forces `pg_pulldown_o` to 1.
- R6: A high `transition_i` forces `pg_pulldown_o` to 1 with no blanking, and the pin is released again through the normal hold-off once the flag drops and the output is in window.
- R7: With the supply above lockout, enable high, no thermal trip, output in window and no transition, `pg_pulldown_o` goes to 0 exactly `HOLD_CYCLES` rising edges after the synchronised inputs first show this good condition. One edge earlier it is still 1. The hold-off counter saturates at `HOLD_CYCLES`.
- R8: Any interruption of the good condition, even for a single cycle, restarts the hold-off count from zero.
- R9: While the supply is below lockout, `pg_pulldown_o` is 0 and the first-enable record is cleared. When the supply returns, R2 applies again. After reset, both outputs are 0.
- R10: `pg_status_o` is registered: on each edge it takes 1 when the supply is above lockout and the pin is released, and 0 otherwise. It therefore follows `pg_pulldown_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Input supply above lockout (asynchronous) |
| enable_i | input | 1 | Device enable (asynchronous) |
| thermal_trip_i | input | 1 | Thermal shutdown active (asynchronous) |
| in_window_i | input | 1 | Output voltage in target window (asynchronous) |
| transition_i | input | 1 | Output voltage change in progress (asynchronous) |
| pg_pulldown_o | output | 1 | 1 = pull pin low, 0 = release to high impedance |
| pg_status_o | output | 1 | Registered status, 1 = power good (pin released) |

## Verification
The assertions assume that every status input holds for at least two clock cycles once it changes, so that the synchronised copies are the values the checker reasons about. They also assume that a glitch shorter than the sampling period counts as no event. The bench drives inputs only just after a rising edge and keeps each level for at least one full cycle. Its single-cycle dropout on the window input is placed so that it is captured, which makes the restart of the count observable.

// File: rtl/pg_indicator.sv
module pg_indicator #(
  parameter int HOLD_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic enable_i,
  input  logic thermal_trip_i,
  input  logic in_window_i,
  input  logic transition_i,
  output logic pg_pulldown_o,
  output logic pg_status_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_CYCLES);

  logic [4:0] sync1, sync2;
  logic s_sup, s_en, s_th, s_win, s_tr;
  logic armed;
  logic [CW-1:0] cnt;
  logic bad, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {supply_ok_i, enable_i, thermal_trip_i, in_window_i, transition_i};
      sync2 <= sync1;
    end
  end

  assign {s_sup, s_en, s_th, s_win, s_tr} = sync2;

  assign bad  = !s_en || s_th || !s_win || s_tr;
  assign done = (cnt == HOLD_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (!s_sup)     armed <= 1'b0;
    else if (s_en)       armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!s_sup || bad)   cnt <= '0;
    else if (!done)           cnt <= cnt + 1'b1;
  end

  assign pg_pulldown_o = s_sup && (armed || s_en) && (bad || !done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_status_o <= 1'b0;
    else        pg_status_o <= s_sup && !pg_pulldown_o;
  end
endmodule

module pg_indicator_chk #(
  parameter int HOLD_CYCLES = 256,
  parameter int CW = 9
) (
  input logic clk,
  input logic rst_n,
  input logic s_sup,
  input logic s_en,
  input logic s_th,
  input logic s_win,
  input logic s_tr,
  input logic armed,
  input logic [CW-1:0] cnt,
  input logic pg_pulldown_o,
  input logic pg_status_o
);
  AST_PRE_ENABLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    s_sup && !armed && !s_en |-> !pg_pulldown_o); // R2
  AST_THERMAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    s_sup && armed && s_th |-> pg_pulldown_o); // R4
  AST_TRANSITION_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    s_sup && armed && s_tr |-> pg_pulldown_o); // R6
  AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_pulldown_o) && s_sup && armed |-> cnt == CW'(HOLD_CYCLES)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HOLD_CYCLES)); // R7
  AST_DROPOUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    s_sup && !s_win |=> cnt == '0); // R8
  AST_UVLO_CLEARS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !s_sup |=> !armed); // R9
  AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pg_status_o |-> $past(!pg_pulldown_o)); // R10
endmodule

bind pg_indicator pg_indicator_chk #(.HOLD_CYCLES(HOLD_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_sup(s_sup), .s_en(s_en), .s_th(s_th),
  .s_win(s_win), .s_tr(s_tr), .armed(armed), .cnt(cnt),
  .pg_pulldown_o(pg_pulldown_o), .pg_status_o(pg_status_o));

// File: tb/tb_pg_indicator.sv
module tb_pg_indicator;
  localparam int H = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup = 1'b0, en = 1'b0, th = 1'b0, win = 1'b0, tr = 1'b0;
  logic pd, st;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pg_indicator #(.HOLD_CYCLES(H)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(sup), .enable_i(en),
    .thermal_trip_i(th), .in_window_i(win), .transition_i(tr),
    .pg_pulldown_o(pd), .pg_status_o(st));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(pd, 1'b0, "R9 reset pulldown");
    check(st, 1'b0, "R9 reset status");
  endtask

  task automatic t_pre_enable;
    sup = 1'b1; win = 1'b0; th = 1'b1; tr = 1'b1;
    tick(4);
    check(pd, 1'b0, "R2 released before first enable");
    check(st, 1'b1, "R10 status while released");
    th = 1'b0; tr = 1'b0;
    tick(3);
  endtask

  task automatic t_enable_latency;
    en = 1'b1;
    tick(1);
    check(pd, 1'b0, "R1 no change after first edge");
    tick(1);
    check(pd, 1'b1, "R1/R5 low after second edge, out of window");
    tick(1);
    check(st, 1'b0, "R10 status follows one cycle later");
  endtask

  task automatic t_release;
    win = 1'b1;
    tick(H + 1);
    check(pd, 1'b1, "R7 still low one edge before hold-off end");
    tick(1);
    check(pd, 1'b0, "R7 released after hold-off");
    check(st, 1'b0, "R10 status not yet updated");
    tick(1);
    check(st, 1'b1, "R10 status good");
  endtask

  task automatic t_dropout;
    win = 1'b0;
    tick(2);
    check(pd, 1'b1, "R5 low when below target");
    win = 1'b1;
    tick(100);
    win = 1'b0;
    tick(1);
    win = 1'b1;
    tick(H + 1);
    check(pd, 1'b1, "R8 count restarted after dropout");
    tick(1);
    check(pd, 1'b0, "R8 released after full hold-off");
  endtask

  task automatic t_transition;
    tr = 1'b1;
    tick(1);
    check(pd, 1'b0, "R1 transition not seen after one edge");
    tick(1);
    check(pd, 1'b1, "R6 low at once during transition");
    tick(20);
    check(pd, 1'b1, "R6 held low through transition");
    tr = 1'b0;
    tick(H + 1);
    check(pd, 1'b1, "R6 hold-off after transition");
    tick(1);
    check(pd, 1'b0, "R6 released after new target");
  endtask

  task automatic t_thermal;
    th = 1'b1; win = 1'b0; tr = 1'b1;
    tick(2);
    check(pd, 1'b1, "R4 low in thermal shutdown");
    tr = 1'b0; win = 1'b1;
    tick(10);
    check(pd, 1'b1, "R4 low regardless of window");
    th = 1'b0;
    tick(H + 2);
    check(pd, 1'b0, "R4 released after thermal clears");
  endtask

  task automatic t_enable_low;
    en = 1'b0;
    tick(2);
    check(pd, 1'b1, "R3 low when disabled");
    tick(H + 10);
    check(pd, 1'b1, "R3 stays low while disabled");
    en = 1'b1;
    tick(H + 2);
    check(pd, 1'b0, "R3 released after re-enable");
  endtask

  task automatic t_uvlo;
    sup = 1'b0;
    tick(2);
    check(pd, 1'b0, "R9 no pull-down below lockout");
    tick(1);
    check(st, 1'b0, "R9 status low below lockout");
    en = 1'b0;
    tick(3);
    sup = 1'b1;
    tick(H + 4);
    check(pd, 1'b0, "R9/R2 released until first enable again");
    check(st, 1'b1, "R10 status while released pre-enable");
    en = 1'b1;
    tick(2);
    check(pd, 1'b1, "R9 low at first enable before hold-off");
    tick(H - 1);
    check(pd, 1'b1, "R7 still low before hold-off end");
    tick(1);
    check(pd, 1'b0, "R7 released after hold-off");
  endtask

  initial begin
    t_reset;
    t_pre_enable;
    t_enable_latency;
    t_release;
    t_dropout;
    t_transition;
    t_thermal;
    t_enable_low;
    t_uvlo;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule